// File: doc/BRIEF.md
# Masked Set/Clear Control Register Bank

A small bank of 32-bit control registers that software updates one bit at a time without having to read them first. Each register is treated as four byte lanes. A bus write to a lane carries a one-bit value in its top bit and a seven-bit selector in its lower bits. Every register bit whose selector bit is 1 takes the value. Every other bit keeps its current state.

The bank sits behind a plain bus port with a word address, byte enables, write data and a combinational read path. It also drives every register onto a flat parallel output for downstream control logic. Only bits 0–6 of each lane hold state. The top bit of each lane always reads as 0, so each register has 28 usable bits.

Top module: `cmd_set_clear_bank`

## Requirements
- R1: A synchronous reset with `rst` high clears every stored bit, so `regs_o` and every readback are 0.
- R2: When a lane is written with bit 7 = 1, each register bit whose selector bit (lane bits 0–6) is 1 becomes 1. All other bits are unchanged. For example, 8'h9A written to lane 0 sets register bits 1, 3 and 4.
- R3: When a lane is written with bit 7 = 0, each selected register bit becomes 0. All other bits are unchanged. For example, 8'h1A written to lane 0 clears bits 1, 3 and 4.
- R4: A lane whose `bus_be` bit is 0 is left unchanged, whatever its write data holds.
- R5: A written lane whose selector bits are all 0 is left unchanged, whatever its value bit holds.
- R6: Bit 7 of every lane (register bits 7, 15, 23 and 31) always reads 0, on both `regs_o` and `bus_rdata`.
- R7: Writes to word addresses at or above `NUM_REGS` change no register. Reads from those addresses return 0.
- R8: `bus_rdata` shows the addressed register in the same cycle. A write sampled at a clock edge is visible on `regs_o` and `bus_rdata` from that edge onward.
- R9: The four lanes of one write act independently. Each enabled lane applies its own value bit to its own selected bits.
- R10: In a cycle without `bus_wen`, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_be | input | 4 | Byte-lane enables; bit n covers write-data bits 8n+7..8n |
| bus_wdata | input | 32 | Per lane: bit 7 is the value, bits 6..0 are the selectors |
| bus_rdata | output | 32 | Addressed register, 0 when out of range |
| regs_o | output | NUM_REGS*32 | All registers; register r occupies bits 32r+31..32r |

## Verification
A wrong stored bit appears on `regs_o` at the next clock edge after the faulty write. It stays there until another write touches that bit, so a comparison of every register after each write catches it within one cycle. A fault in decode or lane masking shows up as a change in a register, lane or bit that the write should not have touched. The bench therefore compares all registers against its model after every write. It also reads each register back through the bus, which catches faults in the read multiplexer.

// File: rtl/cmd_set_clear_bank.sv
`timescale 1ns/1ps
module cmd_set_clear_bank #(
  parameter int NUM_REGS = 5,
  parameter int ADDR_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wen,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [3:0]               bus_be,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_REGS*32-1:0]   regs_o
);
  localparam int LANES = 4;

  logic [6:0] st [NUM_REGS][LANES];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = bus_wen && (int'(bus_addr) == r);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [6:0] sel;
      logic       val;
      assign sel = bus_wdata[l*8 +: 7];
      assign val = bus_wdata[l*8 + 7];
      always_ff @(posedge clk) begin
        if (rst)
          st[r][l] <= '0;
        else if (hit && bus_be[l])
          st[r][l] <= val ? (st[r][l] | sel) : (st[r][l] & ~sel);
      end
      assign regs_o[r*32 + l*8 +: 8] = {1'b0, st[r][l]};
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (int'(bus_addr) == r) bus_rdata = regs_o[r*32 +: 32];
  end
endmodule

module cmd_set_clear_bank_chk #(
  parameter int NUM_REGS = 5,
  parameter int ADDR_W   = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_wen,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [3:0]             bus_be,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [NUM_REGS*32-1:0] regs_o
);
  localparam logic [NUM_REGS*32-1:0] HI_MASK = {(NUM_REGS*4){8'h80}};

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> regs_o == '0);

  p_hi_bits_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (regs_o & HI_MASK) == '0 && bus_rdata[31] == 1'b0 && bus_rdata[23] == 1'b0
    && bus_rdata[15] == 1'b0 && bus_rdata[7] == 1'b0);

  p_no_lane_hold_r4: assert property (@(posedge clk) disable iff (rst)
    bus_wen && bus_be == 4'b0000 |=> $stable(regs_o));

  p_oob_write_hold_r7: assert property (@(posedge clk) disable iff (rst)
    bus_wen && int'(bus_addr) >= NUM_REGS |=> $stable(regs_o));

  p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    int'(bus_addr) >= NUM_REGS |-> bus_rdata == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_wen |=> $stable(regs_o));
endmodule

bind cmd_set_clear_bank cmd_set_clear_bank_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/cmd_set_clear_bank_tb_top.sv
`timescale 1ns/1ps
module cmd_set_clear_bank_tb_top;
  localparam int N  = 5;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wen = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N*32-1:0] regs_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [N];

  always #2 clk = ~clk;

  cmd_set_clear_bank #(.NUM_REGS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .regs_o(regs_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
    if (int'(a) < N)
      for (int l = 0; l < 4; l++)
        if (be[l])
          for (int b = 0; b < 7; b++)
            if (d[l*8+b]) mdl[a][l*8+b] = d[l*8+7];
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < N; r++)
      chk(tag, regs_o[r*32 +: 32], mdl[r]);
    for (int r = 0; r < (1 << AW); r++) begin
      @(negedge clk);
      bus_addr = AW'(r);
      #1;
      chk("R8 readback / R7 out of range / R10 idle hold",
          bus_rdata, (r < N) ? mdl[r] : 32'h0);
    end
  endtask

  initial begin
    for (int r = 0; r < N; r++) mdl[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check_all("R1 reset state");

    wr(0, 4'b0001, 32'h0000_009A);
    chk("R2 set bits 1,3,4", regs_o[31:0], 32'h0000_001A);
    wr(0, 4'b0001, 32'h0000_001A);
    chk("R3 clear bits 1,3,4", regs_o[31:0], 32'h0);

    wr(1, 4'b1111, 32'hFFFF_FFFF);
    chk("R6 top bit of lanes stays 0", regs_o[63:32], 32'h7F7F_7F7F);
    wr(1, 4'b1111, 32'h80FF_017F);
    chk("R9 independent lanes, R5 empty selector", regs_o[63:32], 32'h7F7F_7E00);
    wr(1, 4'b0000, 32'h0000_0000);
    wr(1, 4'b0000, 32'h8080_8080);
    chk("R4 all lanes disabled", regs_o[63:32], 32'h7F7F_7E00);
    wr(1, 4'b1000, 32'h0001_0101);
    chk("R4 disabled lanes with data", regs_o[63:32], 32'h7F7F_7E00);
    wr(2, 4'b0100, 32'h0085_0000);
    chk("R8 write visible after edge", regs_o[95:64], 32'h0005_0000);
    wr(5, 4'b1111, 32'hFFFF_FFFF);
    wr(7, 4'b1111, 32'hFFFF_FFFF);
    check_all("R7 out of range write");

    for (int i = 0; i < 1500; i++) begin
      wr(AW'($urandom_range(0, (1 << AW) - 1)), 4'($urandom), $urandom);
      for (int r = 0; r < N; r++)
        chk("R2/R3 random set and clear", regs_o[r*32 +: 32], mdl[r]);
      if (i % 100 == 0) check_all("R8 periodic readback");
    end
    check_all("R10 final state");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule